// File: doc/BRIEF.md
# Oscillator Pulse-Count Readout with Slice Accumulation

This block is the digital back end of a converter that turns an analog column current into the frequency of an oscillator. After a conversion strobe it waits through a programmable settling interval, while the oscillator reaches its final frequency, and ignores every edge in that interval. It then counts the rising edges of the synchronized pulse train for a programmable counting interval. A longer counting interval gives proportionally more pulses, so adjacent result levels sit further apart in count.

A larger count means more high-resistance cells and therefore a smaller stored value. The block maps each count back to a dot-product value with a programmable zero-point count and a programmable count step per level. It rounds the result to the nearest level and limits it to the number of rows. Mapped values are added into an accumulator at the bit weight of the column slice being read, and row-slice repeats of the same column are summed. A start-of-operation strobe clears the accumulator. A one-cycle valid flag marks the final sum after the slice tagged as last.

Top module: `pulse_slice_readout`

## Requirements
- R1: Each rising edge of `pulse_in` that is seen after two synchronizer flops during the counting interval adds exactly one to `raw_count`. A pulse must stay high and low for at least two clock cycles each.
- R2: Edges during the settling interval are not counted. The settling interval begins on the cycle after an accepted `conv_start` and lasts `settle_len`+1 cycles. `raw_count` is cleared when a conversion is accepted.
- R3: Edges after the counting interval (`count_len`+1 cycles) has ended, and edges while idle, leave `raw_count` unchanged.
- R4: `raw_count` saturates at 2^CNT_W−1. `count_ovf` is set when an edge arrives while the count is already at that maximum, and it stays set until the next conversion is accepted. Exactly 2^CNT_W−1 edges leave `count_ovf` at 0.
- R5: The mapped value is (zero_count − raw_count + floor(step/2)) / step, using integer division, which rounds to nearest with halves rounded up. A `count_step` of 0 is treated as 1.
- R6: The mapped value is 0 when `raw_count` ≥ `zero_count`, and it is limited to ROWS at most.
- R7: Conversions with the same `bit_sel` add their mapped values, so row-slice repeats are summed.
- R8: Each mapped value is added shifted left by the `bit_sel` captured at its `conv_start`, which gives a weight of 2^bit_sel.
- R9: `op_clear` sets `result` to 0 on the next cycle and takes priority over a concurrent addition.
- R10: `result_valid` is high for exactly one cycle, the cycle in which `result` first shows the sum that includes the conversion started with `last_slice`=1. It stays low after other conversions.
- R11: After reset the block is idle (`busy`=0), with `result`, `raw_count`, `count_ovf` and `result_valid` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Oscillator pulse train, asynchronous |
| op_clear | input | 1 | Start of operation: clears the accumulator |
| conv_start | input | 1 | Starts one conversion when idle |
| settle_len | input | WIN_W | Settling interval length minus one |
| count_len | input | WIN_W | Counting interval length minus one |
| zero_count | input | CNT_W | Count that corresponds to a value of 0 |
| count_step | input | CNT_W | Counts per value level |
| bit_sel | input | BIT_W | Bit weight of the column slice |
| last_slice | input | 1 | Marks the final conversion of the operation |
| busy | output | 1 | A conversion is in progress |
| raw_count | output | CNT_W | Edge count of the latest conversion |
| count_ovf | output | 1 | Counter saturated and lost an edge |
| result | output | ACC_W | Accumulated weighted sum |
| result_valid | output | 1 | One-cycle flag on the final sum |

## Verification
The assertions check on every cycle that the count stays at zero during settling, never wraps at its maximum, and holds still outside the counting interval. They also check that the overflow flag only appears at full scale, that the valid flag never lasts two cycles, and that a clear empties the accumulator. Only the bench scenarios can show the arithmetic: the exact edge count against the pulses driven, the inverted rounded mapping across every count from 0 past the zero point, and the weighted sum over repeated and shifted slices. The bench also covers the saturation boundary at exactly full scale and one edge beyond it.

// File: rtl/pcr_pkg.sv
// Shared types for the pulse-count readout.
// Assumes: nothing beyond IEEE 1800-2017.
package pcr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_COUNT,
        PH_DONE
    } phase_e;
endpackage

// File: rtl/pcr_sync_edge.sv
// Two-flop synchronizer followed by a rising-edge detector.
// Assumes: the input stays high and low for at least two clock cycles each.
module pcr_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    // Purpose: move the pulse into the clock domain and keep its previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/pcr_window.sv
// Conversion window sequencer and saturating edge counter.
// The settling phase blanks edges; the counting phase counts them.
// Assumes: the lengths are stable while a conversion runs.
module pcr_window #(
    parameter int CNT_W = 8,
    parameter int WIN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic [WIN_W-1:0] settle_len,
    input  logic [WIN_W-1:0] count_len,
    input  logic             rise,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    import pcr_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    phase_e           phase_q;
    logic [WIN_W-1:0] timer_q;

    assign accept = conv_start && (phase_q == PH_IDLE);
    assign busy   = (phase_q != PH_IDLE);
    assign done   = (phase_q == PH_DONE);

    // Purpose: step through the phases and count edges only while counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            timer_q <= '0;
            cnt     <= '0;
            ovf     <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (conv_start) begin
                        phase_q <= PH_SETTLE;
                        timer_q <= settle_len;
                        cnt     <= '0;
                        ovf     <= 1'b0;
                    end
                end
                PH_SETTLE: begin
                    if (timer_q == '0) begin
                        phase_q <= PH_COUNT;
                        timer_q <= count_len;
                    end else begin
                        timer_q <= timer_q - 1'b1;
                    end
                end
                PH_COUNT: begin
                    if (rise) begin
                        if (cnt == CNT_MAX) ovf <= 1'b1;
                        else                cnt <= cnt + 1'b1;
                    end
                    if (timer_q == '0) phase_q <= PH_DONE;
                    else               timer_q <= timer_q - 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_SETTLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SETTLE) |-> (cnt == '0)); // R2
    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_COUNT && !accept) |=> $stable(cnt)); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_COUNT && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R4
    AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (cnt == CNT_MAX)); // R4
endmodule

// File: rtl/pcr_value_map.sv
// Inverted count-to-value mapping with rounding to nearest and clamping.
// Assumes: zero_cnt is the count for value 0 and step is counts per level.
module pcr_value_map #(
    parameter int CNT_W = 8,
    parameter int ROWS  = 16,
    parameter int VAL_W = 5
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] zero_cnt,
    input  logic [CNT_W-1:0] step,
    output logic [VAL_W-1:0] value
);
    localparam logic [CNT_W:0] ROWS_W = (CNT_W+1)'(ROWS);

    logic [CNT_W-1:0] step_eff;
    logic [CNT_W:0]   num;
    logic [CNT_W:0]   quo;

    // Purpose: compute the rounded, limited value from the count distance.
    always_comb begin
        step_eff = (step == '0) ? CNT_W'(1) : step;
        num      = {1'b0, zero_cnt - cnt} + {2'b00, step_eff[CNT_W-1:1]};
        quo      = num / {1'b0, step_eff};
        if (cnt >= zero_cnt)  value = '0;
        else if (quo > ROWS_W) value = VAL_W'(ROWS);
        else                   value = VAL_W'(quo);
    end
endmodule

// File: rtl/pcr_accum.sv
// Shift-and-add accumulator over weight-bit slices and row-slice repeats.
// Assumes: the number of conversions per operation stays within MAX_REPS per bit.
module pcr_accum #(
    parameter int VAL_W = 5,
    parameter int BIT_W = 2,
    parameter int ACC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_clear,
    input  logic             accept,
    input  logic [BIT_W-1:0] bit_sel,
    input  logic             last_slice,
    input  logic             done,
    input  logic [VAL_W-1:0] value,
    output logic [ACC_W-1:0] acc,
    output logic             valid
);
    logic [BIT_W-1:0] bit_q;
    logic             last_q;
    logic [ACC_W-1:0] term;

    assign term = ACC_W'(value) << bit_q;

    // Purpose: capture the slice tags of the conversion being started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            last_q <= 1'b0;
        end else if (accept) begin
            bit_q  <= bit_sel;
            last_q <= last_slice;
        end
    end

    // Purpose: clear or add the weighted value, and flag the final sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            valid <= 1'b0;
        end else begin
            if (op_clear)  acc <= '0;
            else if (done) acc <= acc + term;
            valid <= done && last_q && !op_clear;
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R10
    AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(done)); // R10
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        op_clear |=> (acc == '0)); // R9
    AST_ACC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_clear |=> (acc >= $past(acc))); // R7
endmodule

// File: rtl/pulse_slice_readout.sv
// Top: pulse-count readout of an oscillator converter with slice accumulation.
// Assumes: one conversion at a time; conv_start is ignored while busy.
module pulse_slice_readout #(
    parameter int CNT_W    = 8,
    parameter int WIN_W    = 12,
    parameter int ROWS     = 16,
    parameter int WBITS    = 4,
    parameter int MAX_REPS = 4,
    localparam int VAL_W   = $clog2(ROWS + 1),
    localparam int BIT_W   = (WBITS > 1) ? $clog2(WBITS) : 1,
    localparam int ACC_W   = $clog2(ROWS * MAX_REPS * ((1 << WBITS) - 1) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             op_clear,
    input  logic             conv_start,
    input  logic [WIN_W-1:0] settle_len,
    input  logic [WIN_W-1:0] count_len,
    input  logic [CNT_W-1:0] zero_count,
    input  logic [CNT_W-1:0] count_step,
    input  logic [BIT_W-1:0] bit_sel,
    input  logic             last_slice,
    output logic             busy,
    output logic [CNT_W-1:0] raw_count,
    output logic             count_ovf,
    output logic [ACC_W-1:0] result,
    output logic             result_valid
);
    logic             rise;
    logic             accept;
    logic             done;
    logic [VAL_W-1:0] value;

    pcr_sync_edge i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pulse_in),
        .rise_o   (rise)
    );

    pcr_window #(.CNT_W(CNT_W), .WIN_W(WIN_W)) i_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .settle_len (settle_len),
        .count_len  (count_len),
        .rise       (rise),
        .accept     (accept),
        .busy       (busy),
        .done       (done),
        .cnt        (raw_count),
        .ovf        (count_ovf)
    );

    pcr_value_map #(.CNT_W(CNT_W), .ROWS(ROWS), .VAL_W(VAL_W)) i_map (
        .cnt      (raw_count),
        .zero_cnt (zero_count),
        .step     (count_step),
        .value    (value)
    );

    pcr_accum #(.VAL_W(VAL_W), .BIT_W(BIT_W), .ACC_W(ACC_W)) i_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_clear   (op_clear),
        .accept     (accept),
        .bit_sel    (bit_sel),
        .last_slice (last_slice),
        .done       (done),
        .value      (value),
        .acc        (result),
        .valid      (result_valid)
    );

    AST_MAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (value <= VAL_W'(ROWS))); // R6
endmodule

// File: tb/test_pulse_slice_readout.sv
// Bench: drives pulse bursts inside and outside the window and checks counts,
// mapped values and weighted sums against arithmetic from the requirements.
module test_pulse_slice_readout;
    localparam int CNT_W = 8;
    localparam int WIN_W = 12;
    localparam int ROWS  = 16;
    localparam int ZERO  = 68;
    localparam int STEP  = 4;
    localparam int ACC_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pulse_in = 1'b0;
    logic             op_clear = 1'b0;
    logic             conv_start = 1'b0;
    logic [WIN_W-1:0] settle_len = 12'd40;
    logic [WIN_W-1:0] count_len = 12'd300;
    logic [CNT_W-1:0] zero_count = 8'(ZERO);
    logic [CNT_W-1:0] count_step = 8'(STEP);
    logic [1:0]       bit_sel = 2'd0;
    logic             last_slice = 1'b0;
    logic             busy;
    logic [CNT_W-1:0] raw_count;
    logic             count_ovf;
    logic [ACC_W-1:0] result;
    logic             result_valid;

    int checks = 0;
    int errors = 0;
    bit valid_seen;

    always #2 clk = ~clk;

    pulse_slice_readout i_pulse_slice_readout (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .op_clear(op_clear),
        .conv_start(conv_start), .settle_len(settle_len), .count_len(count_len),
        .zero_count(zero_count), .count_step(count_step), .bit_sel(bit_sel),
        .last_slice(last_slice), .busy(busy), .raw_count(raw_count),
        .count_ovf(count_ovf), .result(result), .result_valid(result_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_map(input int c);
        int q;
        if (c >= ZERO) return 0;
        q = (ZERO - c + STEP / 2) / STEP;
        return (q > ROWS) ? ROWS : q;
    endfunction

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) begin
            pulse_in = 1'b1;
            repeat (2) @(negedge clk);
            pulse_in = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    // One conversion: ns pulses while settling, np pulses while counting.
    task automatic convert(input int b, input bit last, input int ns, input int np);
        @(negedge clk);
        bit_sel = 2'(b);
        last_slice = last;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        burst(ns);
        repeat (50 - 4 * ns) @(negedge clk);
        burst(np);
        while (busy) @(negedge clk);
        valid_seen = result_valid;
    endtask

    task automatic clear_acc();
        @(negedge clk);
        op_clear = 1'b1;
        @(negedge clk);
        op_clear = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int sum;
        int held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 result", result, 0);
        chk("R11 raw_count", raw_count, 0);
        chk("R11 count_ovf", count_ovf, 0);
        chk("R11 result_valid", result_valid, 0);

        // R1 and R2: settling pulses ignored, counting pulses counted once each
        convert(0, 1'b1, 4, 10);
        chk("R2 settle blanked", raw_count, 10);
        chk("R1 edge count", raw_count, 10);
        chk("R10 valid after last", valid_seen, 1);
        @(negedge clk);
        chk("R10 valid single cycle", result_valid, 0);

        // R3: pulses while idle leave the count alone
        held = raw_count;
        burst(6);
        chk("R3 idle pulses", raw_count, held);

        // R5 and R6: exhaustive count sweep through the inverted mapping
        for (int c = 0; c <= 70; c++) begin
            clear_acc();
            convert(0, 1'b1, 2, c);
            chk("R1 sweep count", raw_count, c);
            chk((c == 0 || c >= ZERO) ? "R6 clamp" : "R5 map", result, exp_map(c));
        end

        // R9: clear empties the accumulator
        clear_acc();
        chk("R9 clear", result, 0);

        // R7, R8, R10: repeats summed, bit slices shifted, valid only at end
        sum = 0;
        convert(0, 1'b0, 1, 20); sum += exp_map(20);
        chk("R10 no valid mid", valid_seen, 0);
        chk("R7 first repeat", result, sum);
        convert(0, 1'b0, 0, 60); sum += exp_map(60);
        chk("R7 second repeat", result, sum);
        convert(1, 1'b0, 3, 28); sum += exp_map(28) << 1;
        chk("R8 bit one", result, sum);
        convert(1, 1'b0, 0, 44); sum += exp_map(44) << 1;
        convert(3, 1'b1, 2, 4);  sum += exp_map(4) << 3;
        chk("R8 weighted sum", result, sum);
        chk("R10 valid on last", valid_seen, 1);

        // R4: exactly full scale, then one edge beyond
        count_len = 12'd1200;
        clear_acc();
        convert(0, 1'b1, 0, 255);
        chk("R4 full scale count", raw_count, 255);
        chk("R4 no overflow at full scale", count_ovf, 0);
        convert(0, 1'b1, 0, 260);
        chk("R4 saturated count", raw_count, 255);
        chk("R4 overflow flag", count_ovf, 1);
        count_len = 12'd300;
        convert(0, 1'b1, 0, 5);
        chk("R4 overflow cleared", count_ovf, 0);

        finish_run();
    end
endmodule